// File: doc/BRIEF.md
# Triggered Hit Pipeline Readout

This block sits behind the comparators of a two-layer binary strip front end. Every clock cycle it stores the hit vectors of both sensor layers, 127 channels each, in a circular pipeline of 256 columns. When a level-1 trigger arrives, it picks the column written a programmed number of cycles earlier and moves it into an event buffer with 32 slots. A serialiser then drains the buffer one event at a time. Each event leaves as an unsparsified frame on a single data line.

Every frame begins with a short header: a start pattern, an error flag and the pipeline column address. The 254 hit bits follow, with the upper and lower layers interleaved channel by channel. Triggers that arrive while the event buffer is full are dropped, and a sticky error flag records the loss. A fast reset puts the pointers, the buffer, the flag and the serialiser back into their initial state. It leaves the stored pipeline contents untouched.

Top module: `trig_pipe_readout`

## Requirements
- R1: After `rst`, `sdata` stays 0 until a trigger is accepted.
- R2: A trigger sampled at clock edge n reads out the hit vectors sampled at edge n-L, where L is `latency` (legal range 1 to 255, L=0 is not allowed). Each accepted trigger produces exactly one frame.
- R3: A frame is 265 bits long and is sent most significant bit first, one bit per cycle. The order is: bits 1 and 1 (start pattern), then the error bit, then the 8-bit column address (MSB first), then upper[0], lower[0], upper[1], lower[1], ..., upper[126], lower[126]. Here upper is `hits_upper` and lower is `hits_lower`. Outside frames, `sdata` is 0.
- R4: The header column address equals (W - L) mod 256. W is the number of clock edges since the last `rst` or `fast_rst` was released; the first such edge writes column 0.
- R5: Frames leave in trigger order. A frame that is waiting starts in the cycle right after the last bit of the previous frame, with no idle gap. The buffer holds up to 32 events, and an event leaves the buffer when its frame starts.
- R6: A trigger whose event reaches the buffer while 32 events are held is dropped and sets a sticky overflow flag. The error bit of a frame equals that flag at the moment the frame starts. Only `rst` or `fast_rst` clears the flag.
- R7: `fast_rst` sampled high aborts any frame in progress (`sdata` is 0 after that edge). It also empties the buffer, clears the flag and restarts the column counter at 0.
- R8: With the buffer empty and the line idle, a trigger sampled at edge n puts the first start bit on `sdata` after edge n+2. `sdata` is still 0 after edges n and n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_rst | input | 1 | Synchronous fast reset of pointers, buffer, flag and serialiser |
| hits_lower | input | 127 | Lower-layer comparator hits for this cycle |
| hits_upper | input | 127 | Upper-layer comparator hits for this cycle |
| trigger | input | 1 | Level-1 trigger strobe, one cycle per trigger |
| latency | input | 8 | Trigger latency in cycles, 1 to 255 |
| sdata | output | 1 | Serial frame output, registered |

## Verification
The checker assumes that `latency` is never 0 outside reset. With a latency of 0 the read column would coincide with the column being written, and the readout would have no defined meaning. The stimulus sets a legal latency before reset is released. It only changes the latency while the line is idle, and it lets at least 255 cycles of known hit data reach the pipeline before the first trigger after a reset. It also assumes that `trigger` is only raised outside reset. The bench drives triggers only once both resets have been low for at least one edge.

// File: rtl/tpr_pkg.sv
`timescale 1ns/1ps
package tpr_pkg;
  // Frame start pattern, transmitted first.
  localparam int START_W = 2;
  localparam logic [START_W-1:0] START_PAT = 2'b11;
  // Header bits besides the column address: start pattern plus error bit.
  localparam int HDR_FIXED_W = START_W + 1;
endpackage

// File: rtl/tpr_pipe_ram.sv
`timescale 1ns/1ps
module tpr_pipe_ram #(
  parameter int WIDTH = 254,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    lat,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rdata,
  output logic [AW-1:0]    raddr_q,
  output logic             rvalid
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    raddr;

  // Column written lat cycles ago; a nonzero latency keeps it off the write column.
  assign raddr = wptr - lat;

  always_ff @(posedge clk) begin
    mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr    <= '0;
      raddr_q <= '0;
      rvalid  <= 1'b0;
    end else begin
      wptr    <= wptr + 1'b1;
      raddr_q <= raddr;
      rvalid  <= rd_en;
    end
  end
endmodule

// File: rtl/tpr_event_fifo.sv
`timescale 1ns/1ps
module tpr_event_fifo #(
  parameter int WIDTH = 262,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     push,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     pop,
  output logic [WIDTH-1:0]         rdata,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     overflow
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp;
  logic [PW-1:0]    rp;
  logic             wr;
  logic             rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wr    = push && !full;
  assign rd    = pop && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/tpr_frame_ser.sv
`timescale 1ns/1ps
module tpr_frame_ser #(
  parameter int NCH = 127,
  parameter int AW  = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ev_valid,
  input  logic [AW-1:0]    ev_addr,
  input  logic [2*NCH-1:0] ev_hits,   // {upper, lower}
  input  logic             err,
  output logic             load,
  output logic             sdata
);
  localparam int HIT_W   = 2 * NCH;
  localparam int FRAME_W = tpr_pkg::HDR_FIXED_W + AW + HIT_W;
  localparam int LW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [LW-1:0]      left;
  logic [HIT_W-1:0]   woven;

  // Upper channel k goes out just ahead of lower channel k.
  for (genvar k = 0; k < NCH; k++) begin : g_weave
    assign woven[HIT_W-1-2*k] = ev_hits[NCH+k];
    assign woven[HIT_W-2-2*k] = ev_hits[k];
  end

  // Load when idle or while the final bit of the current frame is on the line.
  assign load  = ev_valid && (left <= LW'(1));
  assign sdata = shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (clr) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= {tpr_pkg::START_PAT, err, ev_addr, woven};
      left  <= LW'(FRAME_W);
    end else begin
      shreg <= shreg << 1;
      if (left != '0) left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/trig_pipe_readout.sv
`timescale 1ns/1ps
module trig_pipe_readout #(
  parameter int CH_PER_LAYER = 127,
  parameter int ADDR_W       = 8,
  parameter int EVT_DEPTH    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fast_rst,
  input  logic [CH_PER_LAYER-1:0] hits_lower,
  input  logic [CH_PER_LAYER-1:0] hits_upper,
  input  logic                    trigger,
  input  logic [ADDR_W-1:0]       latency,
  output logic                    sdata
);
  localparam int HIT_W = 2 * CH_PER_LAYER;
  localparam int EVT_W = ADDR_W + HIT_W;
  localparam int CNT_W = $clog2(EVT_DEPTH) + 1;

  logic              clr;
  logic [HIT_W-1:0]  col_hits;
  logic [ADDR_W-1:0] col_addr;
  logic              ev_push;
  logic [EVT_W-1:0]  ev_head;
  logic              ev_empty;
  logic              ev_full;
  logic [CNT_W-1:0]  ev_count;
  logic              ovf_flag;
  logic              ser_load;

  assign clr = rst | fast_rst;

  tpr_pipe_ram #(.WIDTH(HIT_W), .AW(ADDR_W)) u_pipe (
    .clk     (clk),
    .clr     (clr),
    .wdata   ({hits_upper, hits_lower}),
    .lat     (latency),
    .rd_en   (trigger),
    .rdata   (col_hits),
    .raddr_q (col_addr),
    .rvalid  (ev_push)
  );

  tpr_event_fifo #(.WIDTH(EVT_W), .DEPTH(EVT_DEPTH)) u_evbuf (
    .clk      (clk),
    .clr      (clr),
    .push     (ev_push),
    .wdata    ({col_addr, col_hits}),
    .pop      (ser_load),
    .rdata    (ev_head),
    .empty    (ev_empty),
    .full     (ev_full),
    .count    (ev_count),
    .overflow (ovf_flag)
  );

  tpr_frame_ser #(.NCH(CH_PER_LAYER), .AW(ADDR_W)) u_ser (
    .clk      (clk),
    .clr      (clr),
    .ev_valid (!ev_empty),
    .ev_addr  (ev_head[EVT_W-1 -: ADDR_W]),
    .ev_hits  (ev_head[HIT_W-1:0]),
    .err      (ovf_flag),
    .load     (ser_load),
    .sdata    (sdata)
  );
endmodule

// File: rtl/trig_pipe_readout_chk.sv
`timescale 1ns/1ps
module trig_pipe_readout_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          fast_rst,
  input logic [AW-1:0] latency,
  input logic          sdata,
  input logic [CW-1:0] ev_count,
  input logic          ev_push,
  input logic          ev_full,
  input logic          ovf_flag,
  input logic          ser_load
);
  // R2: input assumption, latency must be legal
  p_lat_legal_r2: assert property (@(posedge clk) disable iff (rst)
    latency != '0);

  // R5: buffer never holds more than its depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    ev_count <= CW'(DEPTH));

  // R6: an event arriving at a full buffer raises the flag
  p_drop_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_push && ev_full && !fast_rst) |=> ovf_flag);

  // R6: flag is sticky until a reset
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !fast_rst) |=> ovf_flag);

  // R3: a frame start puts a start bit on the line next cycle
  p_frame_start_r3: assert property (@(posedge clk) disable iff (rst)
    (ser_load && !fast_rst) |=> sdata);

  // R7: fast reset silences the line
  p_fast_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    fast_rst |=> !sdata);
endmodule

bind trig_pipe_readout trig_pipe_readout_chk #(
  .AW(ADDR_W), .DEPTH(EVT_DEPTH), .CW(CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fast_rst (fast_rst),
  .latency  (latency),
  .sdata    (sdata),
  .ev_count (ev_count),
  .ev_push  (ev_push),
  .ev_full  (ev_full),
  .ovf_flag (ovf_flag),
  .ser_load (ser_load)
);

// File: tb/test_trig_pipe_readout.sv
`timescale 1ns/1ps
module test_trig_pipe_readout;
  localparam int NCH  = 127;
  localparam int AW   = 8;
  localparam int DEP  = 32;
  localparam int HW   = 2 * NCH;
  localparam int FW   = 3 + AW + HW;
  localparam int MAXF = 64;

  typedef struct packed { int lat; int mode; int seed; } vec_t;
  localparam vec_t VECS [6] = '{
    '{1, 0, 3}, '{255, 0, 9}, '{2, 1, 0}, '{100, 2, 1}, '{37, 3, 0}, '{200, 0, 17}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frst = 1'b0;
  logic trig = 1'b0;
  logic [NCH-1:0] up_h = '0;
  logic [NCH-1:0] lo_h = '0;
  logic [AW-1:0] lat = 8'd1;
  logic sdata;

  always #2.5 clk = ~clk;

  trig_pipe_readout #(.CH_PER_LAYER(NCH), .ADDR_W(AW), .EVT_DEPTH(DEP)) i_trig_pipe_readout (
    .clk(clk), .rst(rst), .fast_rst(frst), .hits_lower(lo_h), .hits_upper(up_h),
    .trigger(trig), .latency(lat), .sdata(sdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int pat_mode = 0;
  int pat_seed = 0;
  int drv_cyc = 0;
  int n_seen = 0;
  int skip = 0;
  logic err_hint = 1'b0;

  // ---------------- reference model of expected frames ----------------
  logic [HW-1:0] hist [256];
  logic [AW-1:0] m_wptr = '0;
  logic [AW-1:0] m_ea;
  int n_exp = 0;
  logic [AW-1:0] exp_addr [MAXF];
  logic [HW-1:0] exp_hits [MAXF];
  logic          exp_err  [MAXF];

  function automatic logic [HW-1:0] weave(input logic [HW-1:0] v);
    logic [HW-1:0] r;
    for (int k = 0; k < NCH; k++) begin
      r[HW-1-2*k] = v[NCH+k];
      r[HW-2-2*k] = v[k];
    end
    return r;
  endfunction

  function automatic logic [NCH-1:0] gen(input int mode, input int seed, input int cyc, input int layer);
    logic [NCH-1:0] r;
    for (int k = 0; k < NCH; k++) begin
      case (mode)
        0:       r[k] = ((cyc * 31 + k * 7 + seed + layer * 5) % 11) < 3;
        1:       r[k] = (layer == 1);
        2:       r[k] = ((k + cyc + layer) % 2) == 0;
        default: r[k] = (k == 0 || k == NCH - 1) && ((cyc + layer) % 3 == 0);
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst || frst) begin
      m_wptr <= '0;
      n_exp  <= 0;
    end else begin
      hist[m_wptr] <= {up_h, lo_h};
      if (trig) begin
        m_ea = m_wptr - lat;
        if (n_exp < MAXF) begin
          exp_addr[n_exp] <= m_ea;
          exp_hits[n_exp] <= weave(hist[m_ea]);
          exp_err[n_exp]  <= err_hint;
        end
        n_exp <= n_exp + 1;
      end
      m_wptr <= m_wptr + 1'b1;
    end
  end

  // ---------------- frame capture, sampled at falling edges ----------------
  logic [FW-1:0] recv [MAXF];
  int n_recv = 0;
  logic cap_on = 1'b0;
  logic [FW-1:0] cap_sh = '0;
  int cap_n = 0;

  always @(negedge clk) begin
    if (rst || frst) begin
      cap_on = 1'b0;
      n_recv = 0;
    end else if (!cap_on) begin
      if (sdata === 1'b1) begin
        cap_on = 1'b1;
        cap_sh = {{(FW-1){1'b0}}, 1'b1};
        cap_n  = 1;
      end
    end else begin
      cap_sh = {cap_sh[FW-2:0], sdata};
      cap_n++;
      if (cap_n == FW) begin
        if (n_recv < MAXF) recv[n_recv] = cap_sh;
        n_recv++;
        cap_on = 1'b0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      drv_cyc++;
      up_h = gen(pat_mode, pat_seed, drv_cyc, 1);
      lo_h = gen(pat_mode, pat_seed, drv_cyc, 0);
    end
  endtask

  task automatic fire(input logic e);
    trig = 1'b1;
    err_hint = e;
    tick(1);
    trig = 1'b0;
  endtask

  task automatic check_frames(input string req);
    for (int i = n_seen; i < n_recv; i++) begin
      logic [FW-1:0] f;
      int j;
      f = recv[i];
      j = i + skip;
      chk(f[FW-1 -: 2] == 2'b11, "R3 start pattern", FW'(f[FW-1 -: 2]), FW'(2'b11));
      chk(f[HW+AW-1:HW] == exp_addr[j], "R4 column address", FW'(f[HW+AW-1:HW]), FW'(exp_addr[j]));
      chk(f[FW-3] == exp_err[j], "R6 error bit", FW'(f[FW-3]), FW'(exp_err[j]));
      chk(f[HW-1:0] == exp_hits[j], {req, " hit bits"}, FW'(f[HW-1:0]), FW'(exp_hits[j]));
    end
    n_seen = n_recv;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ones;
    tick(5);
    rst = 1'b0;
    // R1: idle line after reset
    ones = 0;
    repeat (20) begin
      @(negedge clk);
      if (sdata !== 1'b0) ones++;
    end
    chk(ones == 0, "R1 idle after reset", FW'(ones), '0);
    tick(300);

    // Table-driven latency and pattern sweep (R2, R3, R4)
    for (int v = 0; v < 6; v++) begin
      lat = AW'(VECS[v].lat);
      pat_mode = VECS[v].mode;
      pat_seed = VECS[v].seed;
      tick(300);
      fire(1'b0);
      tick(300);
      chk(n_recv == n_seen + 1, "R2 one frame per trigger", FW'(n_recv - n_seen), FW'(1));
      check_frames("R2");
    end

    // R8: trigger to first start bit
    lat = 8'd20;
    pat_mode = 0;
    tick(300);
    trig = 1'b1;
    err_hint = 1'b0;
    @(posedge clk);
    #1 trig = 1'b0;
    @(negedge clk); chk(sdata == 1'b0, "R8 low after edge n", FW'(sdata), '0);
    @(negedge clk); chk(sdata == 1'b0, "R8 low after edge n+1", FW'(sdata), '0);
    @(negedge clk); chk(sdata == 1'b1, "R8 start bit after edge n+2", FW'(sdata), FW'(1));
    tick(300);
    check_frames("R8");

    // R5: two triggers back to back, frames in order without a gap
    trig = 1'b1;
    err_hint = 1'b0;
    tick(2);
    trig = 1'b0;
    tick(600);
    chk(n_recv == n_seen + 2, "R5 two contiguous frames", FW'(n_recv - n_seen), FW'(2));
    check_frames("R5");

    // R6: 40 consecutive triggers, 33 accepted, later frames flagged
    trig = 1'b1;
    err_hint = 1'b0;
    tick(1);
    err_hint = 1'b1;
    tick(39);
    trig = 1'b0;
    tick(34 * FW + 50);
    chk(n_recv == n_seen + 33, "R6 accepted event count", FW'(n_recv - n_seen), FW'(33));
    check_frames("R6");
    skip = 7;
    fire(1'b1);
    tick(300);
    chk(n_recv == n_seen + 1, "R6 frame after overflow", FW'(n_recv - n_seen), FW'(1));
    check_frames("R6 sticky");

    // R7: fast reset mid-frame with a second event queued
    trig = 1'b1;
    err_hint = 1'b1;
    tick(2);
    trig = 1'b0;
    tick(40);
    frst = 1'b1;
    tick(1);
    frst = 1'b0;
    @(negedge clk);
    chk(sdata == 1'b0, "R7 line low after fast reset", FW'(sdata), '0);
    ones = 0;
    repeat (600) begin
      @(negedge clk);
      if (sdata !== 1'b0) ones++;
    end
    chk(ones == 0, "R7 buffer emptied", FW'(ones), '0);
    n_seen = 0;
    skip = 0;
    tick(30);
    fire(1'b0);
    tick(300);
    chk(n_recv == 1, "R7 frame after fast reset", FW'(n_recv), FW'(1));
    check_frames("R7");

    finish_run();
  end
endmodule